// File: doc/BRIEF.md
# Power-management register interface

This block is the byte-wide register file of a power-management companion device. A simplified serial-slave transaction layer in front of it delivers three kinds of event: a start of a write-direction transfer, a received byte, and a request for a byte to send. The first byte received after a start loads an 8-bit register pointer. Every later received byte is written to the pointed register. Every read returns the pointed register. Both kinds of access then advance the pointer by one, so a host can stream through a run of registers in a single transfer.

The 6-bit address space holds the core-voltage, DC-DC, linear-regulator, sleep, oscillator, detect, GPIO, pull and card-slot control registers. Each register keeps only the bits its write mask allows. Core-voltage codes saturate at a ceiling instead of being stored raw. A few addresses read back constants. Writing bit 0 of the power-off register restores every register to its default. The interrupt and real-time-clock logic sit outside this block. They see every data write through a one-cycle strobe that carries the address and the raw byte.

Top module: `pmic_regif`

## Requirements
- R1: On a received byte, when no data byte has been taken since the last start_i, the byte is loaded into the pointer and no register is written.
- R2: Each later received byte is written to the pointed register, and the pointer then advances by one. The 8-bit pointer wraps from 0xFF to 0x00.
- R3: A read pulse latches the pointed register's read value into rdata_o at the next clock edge, and the pointer then advances by one. rdata_o holds its value between reads.
- R4: Address 0x01 always reads 0x22. Addresses 0x14, 0x1B, 0x1C and 0x39 always read 0x00.
- R5: Addresses 0x02, 0x04 and 0x05 store min(value & 0x1F, 0x12). Address 0x03 stores the full byte. Address 0x06 keeps bits 1:0.
- R6: Write masks are: 0x07→0x3F, 0x08/0x09→0x07, 0x0A→0xFF, 0x0B→0x7F, 0x0C–0x11→0x03, 0x12/0x13→0xFF, 0x16→0x7F, 0x32/0x34→0xFF, 0x33/0x35→0x1F, 0x36→0x7F, 0x37→0xFF, 0x38→0x0F, 0x3A→0x3F.
- R7: Address 0x15 stores bits 2:0 of the written byte. It reads back as that value with bit 7 forced to 1.
- R8: GPIO: direction register 0x1D (mask 0x67, bit n = 1 makes line n an input), output register 0x1F (mask 0x07), gpio_o = bits 2:0 of 0x1F. Address 0x1E reads gpio_i | (~dir[2:0] & out[2:0]) in bits 2:0, and writes to it are ignored.
- R9: Any write to 0x20 stores 0x0D.
- R10: A write to 0x14 with bit 0 set returns every register to its default and sets the pointer to 0x00 at the same edge. With bit 0 clear, the write has no effect on any register.
- R11: After reset the registers hold 0x02=0x0C, 0x03=0x05, 0x04=0x02, 0x05=0x0C, 0x06=0x03, 0x07=0x33, 0x08=0x03, 0x0A=0x95, 0x0B=0x7E, 0x0E=0x03, 0x15=0x01, 0x16=0x09, 0x1D=0x07, 0x36=0x03, 0x37=0xC0, 0x3A=0x05, and all others 0x00. After reset rdata_o, gpio_o and stb_o are 0.
- R12: Addresses with no register (including all pointers at or above 0x40) read 0x00 and ignore writes, and the pointer still advances.
- R13: Every data write (not a pointer load) pulses stb_o for one cycle after the accepting edge, with stb_addr_o set to the pointer used and stb_data_o set to the raw byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start of a write-direction transfer; the next byte is a pointer |
| wr_i | input | 1 | Received byte valid |
| wdata_i | input | 8 | Received byte |
| rd_i | input | 1 | Request for a byte to transmit |
| rdata_o | output | 8 | Byte read at the last request |
| gpio_i | input | 3 | GPIO input pin levels |
| gpio_o | output | 3 | GPIO output latch |
| stb_o | output | 1 | Data-write strobe for neighbouring logic |
| stb_addr_o | output | 8 | Pointer of the strobed write |
| stb_data_o | output | 8 | Raw byte of the strobed write |

## Verification
The assertions check on every cycle that the pointer loads, steps and clears as R1, R2 and R10 require. They also check that clamped voltage codes never exceed 0x12, that the revision, clock-good and unmapped reads return their constants, and that each data write is followed by a matching strobe. Only the bench's scenarios can show the full register model. It sweeps every address with several patterns, writes all 256 values to the clamped codes and reads back the defaults after reset and after a soft clear. It also covers pointer wrap at 0xFF, the GPIO read-back mix and the no-effect write of 0x14 with bit 0 clear.

// File: rtl/pmic_regif_pkg.sv
package pmic_regif_pkg;

  localparam logic [7:0] A_REV  = 8'h01;
  localparam logic [7:0] A_OFF  = 8'h14;
  localparam logic [7:0] A_OSC  = 8'h15;
  localparam logic [7:0] A_DET  = 8'h16;
  localparam logic [7:0] A_GDIR = 8'h1D;
  localparam logic [7:0] A_GIN  = 8'h1E;
  localparam logic [7:0] A_GOUT = 8'h1F;
  localparam logic [7:0] A_BB   = 8'h20;

  localparam logic [7:0] REV_VAL  = 8'h22;
  localparam logic [7:0] VC_MAX   = 8'h12;
  localparam logic [7:0] BB_VAL   = 8'h0D;
  localparam logic [7:0] CLK_GOOD = 8'h80;

  function automatic logic is_store(logic [7:0] a);
    return (a >= 8'h02 && a <= 8'h13) || a == A_OSC || a == A_DET ||
           a == A_GDIR || a == A_GOUT || a == A_BB ||
           (a >= 8'h32 && a <= 8'h38) || a == 8'h3A;
  endfunction

  function automatic logic is_clamp(logic [7:0] a);
    return a == 8'h02 || a == 8'h04 || a == 8'h05;
  endfunction

  function automatic logic [7:0] wmask(logic [7:0] a);
    case (a)
      8'h06, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h10, 8'h11: return 8'h03;
      8'h07, 8'h3A:                                    return 8'h3F;
      8'h08, 8'h09, A_OSC, A_GOUT:                     return 8'h07;
      8'h0B, A_DET, 8'h36:                             return 8'h7F;
      8'h33, 8'h35:                                    return 8'h1F;
      8'h38:                                           return 8'h0F;
      A_GDIR:                                          return 8'h67;
      default:                                         return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] dflt(logic [7:0] a);
    case (a)
      8'h02, 8'h05: return 8'h0C;
      8'h03, 8'h3A: return 8'h05;
      8'h04:        return 8'h02;
      8'h06, 8'h08, 8'h0E, 8'h36: return 8'h03;
      8'h07:        return 8'h33;
      8'h0A:        return 8'h95;
      8'h0B:        return 8'h7E;
      A_OSC:        return 8'h01;
      A_DET:        return 8'h09;
      A_GDIR:       return 8'h07;
      8'h37:        return 8'hC0;
      default:      return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] shape(logic [7:0] a, logic [7:0] v);
    logic [7:0] m;
    if (a == A_BB) return BB_VAL;
    if (is_clamp(a)) begin
      m = v & 8'h1F;
      return (m > VC_MAX) ? VC_MAX : m;
    end
    return v & wmask(a);
  endfunction

endpackage

// File: rtl/regfile_ptr.sv
module regfile_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] wdata_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic             rd_en_o
);
  logic first_q;
  logic load;

  assign load    = wr_i && !start_i && first_q;
  assign wr_en_o = wr_i && !start_i && !first_q;
  assign rd_en_o = rd_i && !start_i && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        first_q <= 1'b0;
    else if (start_i)   first_q <= 1'b1;
    else if (wr_i)      first_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ptr_o <= '0;
    else if (clr_i)               ptr_o <= '0;
    else if (load)                ptr_o <= wdata_i;
    else if (wr_en_o || rd_en_o)  ptr_o <= ptr_o + 1'b1;
  end

  a_r1_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> ptr_o == $past(wdata_i));
  a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !clr_i) |=> ptr_o == $past(ptr_o) + 1'b1);
  a_r3_rd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> ptr_o == $past(ptr_o) + 1'b1);
  a_r10_ptr_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr_o == '0);

endmodule

// File: rtl/regfile_bank.sv
module regfile_bank
  import pmic_regif_pkg::*;
#(
  parameter int AW = 6,
  localparam int NREG = 1 << AW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      soft_clr_i,
  input  logic                      we_i,
  input  logic [AW-1:0]             waddr_i,
  input  logic [7:0]                wdata_i,
  output logic [NREG-1:0][7:0]      q_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] ADR = 8'(i);
    if (is_store(ADR)) begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q_o[i] <= dflt(ADR);
        else if (soft_clr_i)                      q_o[i] <= dflt(ADR);
        else if (we_i && waddr_i == ADR[AW-1:0])  q_o[i] <= shape(ADR, wdata_i);
      end
      if (is_clamp(ADR)) begin : g_chk
        a_r5_vcore_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
          q_o[i] <= VC_MAX);
      end
    end else begin : g_none
      assign q_o[i] = 8'h00;
    end
  end
endmodule

// File: rtl/regfile_rdmux.sv
module regfile_rdmux
  import pmic_regif_pkg::*;
#(
  parameter int AW    = 6,
  parameter int PTR_W = 8,
  localparam int NREG = 1 << AW
) (
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [NREG-1:0][7:0] q_i,
  input  logic [2:0]           gpio_i,
  output logic [7:0]           rdata_o
);
  logic [AW-1:0] idx;
  logic          in_space;
  logic [7:0]    gdir, gout;

  assign idx      = ptr_i[AW-1:0];
  assign in_space = (ptr_i >> AW) == '0;
  assign gdir     = q_i[A_GDIR[AW-1:0]];
  assign gout     = q_i[A_GOUT[AW-1:0]];

  always_comb begin
    rdata_o = 8'h00;
    if (in_space) begin
      case (8'(idx))
        A_REV:   rdata_o = REV_VAL;
        A_OSC:   rdata_o = q_i[idx] | CLK_GOOD;
        A_GIN:   rdata_o = {5'b0, gpio_i | (~gdir[2:0] & gout[2:0])};
        default: rdata_o = q_i[idx];
      endcase
    end
  end
endmodule

// File: rtl/pmic_regif.sv
module pmic_regif
  import pmic_regif_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int AW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             rd_i,
  output logic [7:0]       rdata_o,
  input  logic [2:0]       gpio_i,
  output logic [2:0]       gpio_o,
  output logic             stb_o,
  output logic [PTR_W-1:0] stb_addr_o,
  output logic [7:0]       stb_data_o
);
  localparam int NREG = 1 << AW;

  logic [PTR_W-1:0]     ptr;
  logic                 wr_en, rd_en, in_space, we, soft_clr;
  logic [NREG-1:0][7:0] q;
  logic [7:0]           rd_val;

  assign in_space = (ptr >> AW) == '0;
  assign we       = wr_en && in_space;
  assign soft_clr = we && ptr[AW-1:0] == A_OFF[AW-1:0] && wdata_i[0];

  regfile_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni, .start_i, .wr_i,
    .wdata_i (wdata_i[PTR_W-1:0]),
    .rd_i, .clr_i(soft_clr), .ptr_o(ptr), .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  regfile_bank #(.AW(AW)) u_bank (
    .clk_i, .rst_ni, .soft_clr_i(soft_clr), .we_i(we),
    .waddr_i(ptr[AW-1:0]), .wdata_i, .q_o(q)
  );

  regfile_rdmux #(.AW(AW), .PTR_W(PTR_W)) u_rdmux (
    .ptr_i(ptr), .q_i(q), .gpio_i, .rdata_o(rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= 8'h00;
    else if (rd_en)  rdata_o <= rd_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o      <= 1'b0;
      stb_addr_o <= '0;
      stb_data_o <= 8'h00;
    end else begin
      stb_o <= wr_en;
      if (wr_en) begin
        stb_addr_o <= ptr;
        stb_data_o <= wdata_i;
      end
    end
  end

  assign gpio_o = q[A_GOUT[AW-1:0]][2:0];

  a_r4_rev_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && ptr == PTR_W'(A_REV)) |=> rdata_o == REV_VAL);
  a_r7_clk_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && ptr == PTR_W'(A_OSC)) |=> rdata_o[7]);
  a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && !in_space) |=> rdata_o == 8'h00);
  a_r10_soft_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr |=> (q[A_DET[AW-1:0]] == 8'h09 && q[A_GDIR[AW-1:0]] == 8'h07));
  a_r13_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (stb_o && stb_data_o == $past(wdata_i) && stb_addr_o == $past(ptr)));
  a_r13_strobe_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> !stb_o);

endmodule

// File: tb/pmic_regif_test.sv
module pmic_regif_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [2:0] gpio_in = 3'b000;
  logic [7:0] rdata, stb_addr, stb_data;
  logic [2:0] gpio_out;
  logic       stb;

  int total = 0, bad = 0;
  logic [7:0] mdl [64];

  always #10 clk = ~clk;

  pmic_regif uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .gpio_i(gpio_in), .gpio_o(gpio_out),
    .stb_o(stb), .stb_addr_o(stb_addr), .stb_data_o(stb_data)
  );

  function automatic logic [7:0] m_dflt(int a);
    case (a)
      8'h02: return 8'h0C; 8'h03: return 8'h05; 8'h04: return 8'h02;
      8'h05: return 8'h0C; 8'h06: return 8'h03; 8'h07: return 8'h33;
      8'h08: return 8'h03; 8'h0A: return 8'h95; 8'h0B: return 8'h7E;
      8'h0E: return 8'h03; 8'h15: return 8'h01; 8'h16: return 8'h09;
      8'h1D: return 8'h07; 8'h36: return 8'h03; 8'h37: return 8'hC0;
      8'h3A: return 8'h05;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_store(int a, logic [7:0] v, logic [7:0] old);
    int c;
    case (a)
      8'h02, 8'h04, 8'h05: begin c = v & 8'h1F; return (c > 18) ? 8'h12 : 8'(c); end
      8'h03, 8'h0A, 8'h12, 8'h13, 8'h32, 8'h34, 8'h37: return v;
      8'h06, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h10, 8'h11: return v & 8'h03;
      8'h07, 8'h3A: return v & 8'h3F;
      8'h08, 8'h09, 8'h15, 8'h1F: return v & 8'h07;
      8'h0B, 8'h16, 8'h36: return v & 8'h7F;
      8'h33, 8'h35: return v & 8'h1F;
      8'h38: return v & 8'h0F;
      8'h1D: return v & 8'h67;
      8'h20: return 8'h0D;
      default: return old;
    endcase
  endfunction

  function automatic logic [7:0] m_read(int a);
    if (a >= 64) return 8'h00;
    case (a)
      8'h01: return 8'h22;
      8'h15: return mdl[a] | 8'h80;
      8'h1E: return {5'b0, gpio_in | (~mdl[8'h1D][2:0] & mdl[8'h1F][2:0])};
      default: return mdl[a];
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic do_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic do_wr(logic [7:0] b);
    wr = 1'b1; wdata = b; @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_wr_stb(logic [7:0] a, logic [7:0] b);
    do_wr(b);
    check("R13 stb", {7'b0, stb}, 8'h01);
    check("R13 addr", stb_addr, a);
    check("R13 data", stb_data, b);
  endtask

  task automatic do_rd(string req, logic [7:0] expv);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    check(req, rdata, expv);
  endtask

  task automatic write_reg(int a, logic [7:0] v);
    do_start(); do_wr(8'(a)); do_wr_stb(8'(a), v);
    if (a < 64) mdl[a] = m_store(a, v, mdl[a]);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mdl[i] = m_dflt(i);
  endtask

  task automatic read_all(string req);
    do_start(); do_wr(8'h00);
    for (int i = 0; i < 64; i++) do_rd(req, m_read(i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    gpio_in = 3'b101;
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11 rdata", rdata, 8'h00);
    check("R11 gpio_o", {5'b0, gpio_out}, 8'h00);
    check("R11 stb", {7'b0, stb}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R11 default");

    // R1 pointer load then R3 read
    do_start(); do_wr(8'h16); do_rd("R1 load", 8'h09);
    do_rd("R3 next", 8'h00);
    check("R3 hold", rdata, 8'h00);

    // sweep: every address, several patterns (R6 R5 R7 R8 R9 R12 R4)
    for (int a = 0; a < 64; a++) begin
      if (a == 8'h14) continue;
      for (int k = 0; k < 4; k++) begin
        logic [7:0] v;
        v = (k == 0) ? 8'hFF : (k == 1) ? 8'h00 : (k == 2) ? 8'hA5 : 8'(a * 7 + 19);
        write_reg(a, v);
        do_start(); do_wr(8'(a)); do_rd("R6 sweep", m_read(a));
      end
    end

    // R5 exhaustive clamp
    for (int v = 0; v < 256; v++) begin
      write_reg(8'h04, 8'(v));
      do_start(); do_wr(8'h04); do_rd("R5 clamp", m_read(8'h04));
    end

    // R2 burst write then burst read
    do_start(); do_wr(8'h07);
    do_wr_stb(8'h07, 8'hFF); do_wr_stb(8'h08, 8'hFF); do_wr_stb(8'h09, 8'h15);
    mdl[7] = 8'h3F; mdl[8] = 8'h07; mdl[9] = 8'h05;
    do_start(); do_wr(8'h07);
    do_rd("R2 burst", 8'h3F); do_rd("R2 burst", 8'h07); do_rd("R2 burst", 8'h05);

    // R8 GPIO read mix and output pins
    write_reg(8'h1D, 8'h00); write_reg(8'h1F, 8'h06);
    gpio_in = 3'b001;
    do_start(); do_wr(8'h1E); do_rd("R8 gin", 8'h07);
    check("R8 gpio_o", {5'b0, gpio_out}, 8'h06);
    write_reg(8'h1D, 8'h07);
    do_start(); do_wr(8'h1E); do_rd("R8 gin dir", 8'h01);

    // R2 pointer wrap: FE, FF, 00 then read at 01
    do_start(); do_wr(8'hFE);
    do_wr_stb(8'hFE, 8'h11); do_wr_stb(8'hFF, 8'h22); do_wr_stb(8'h00, 8'h33);
    do_rd("R2 wrap", 8'h22);

    // R12 beyond the space
    do_start(); do_wr(8'h55); do_wr_stb(8'h55, 8'hAA);
    do_start(); do_wr(8'h55); do_rd("R12 high", 8'h00);
    do_rd("R12 step", 8'h00);

    // R4 fixed reads
    do_start(); do_wr(8'h14); do_rd("R4 off", 8'h00);
    do_start(); do_wr(8'h1B); do_rd("R4 ack", 8'h00); do_rd("R4 ack", 8'h00);

    // R10 bit0 clear: no effect
    write_reg(8'h16, 8'h55);
    do_start(); do_wr(8'h14); do_wr_stb(8'h14, 8'hFE);
    do_start(); do_wr(8'h16); do_rd("R10 no clr", 8'h55);

    // R10 soft clear: pointer to 0, defaults back
    do_start(); do_wr(8'h14); do_wr_stb(8'h14, 8'h01);
    model_reset();
    do_rd("R10 ptr0", 8'h00);
    do_rd("R10 ptr1", 8'h22);
    read_all("R10 default");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule